// File: doc/BRIEF.md
# Serial digit scan capture latches

This block turns a character-serial display scan into ten parallel BCD columns held steady for a printing recorder. A 4-bit digit bus carries one character per scan step. Two slow, skewed clocks are passed through two-flop synchronizers and combined by exclusive-OR. Each change of that XOR value is a step event. A start strobe injects an active-low token into a seven-slot selector. Each step event writes into the slot that holds the token, then moves the token one slot on. A rising XOR change (the leading pulse) writes the decimal-point code 15. A falling change (the trailing pulse) writes the digit on the bus. Outside the scanned columns, the block decodes a 3-bit units code into an exponent sign and magnitude, and it flags overflow in the leftmost column. Every output bit is driven in negative logic.

The selector is a two-state machine. In ST_EMPTY no token is present. In ST_SCAN a token sits in one of the seven slots. The transitions are:
- T_START: ST_EMPTY to ST_SCAN, on a start strobe.
- T_RESTART: ST_SCAN to ST_SCAN, on a start strobe; the token returns to slot 0.
- T_STEP: ST_SCAN to ST_SCAN, on a step event while the token is below slot 6.
- T_EXIT: ST_SCAN to ST_EMPTY, on a step event while the token is in slot 6.

Top module: `scan_capture_top`

## Requirements
- R1: While reset is asserted and after it is released, every column's internal value is 0, so `cols_n_o` is all ones, and the selector holds no token.
- R2: Column k (1 to 10) sits at `cols_n_o[4k-1:4k-4]`, and each output bit is the inverse of that column's internal BCD value.
- R3: A step event happens when the XOR of the synchronized clock pair changes. A clock input change first sampled at system edge E takes effect at edge E+2 and is visible on the outputs after that edge. When both clock inputs change in the same sample, there is no event.
- R4: On a step event in ST_SCAN, the token's slot is written. A rising XOR change writes 15. A falling change writes the value of `digit_i` sampled at that edge. The token then moves to the next slot.
- R5: Slot i (0 to 6) maps to column 9-i, so slot 0 is column 9 and slot 6 is column 3. At most one slot holds the token.
- R6: A step event while no token is present writes nothing. A step event with the token in slot 6 writes slot 6 and leaves the selector empty.
- R7: A start strobe, a one-cycle high on `start_i`, places the token in slot 0 and discards any token already present. A step event at the same edge as a start strobe writes nothing.
- R8: On every edge, column 2 is loaded with the sign and column 1 with the magnitude decoded from `units_i`. The codes are 0 = +0, 1 = +3, 2 = +6, 3 = -0, 4 = -3, 5 = -6, 6 = -0 and 7 = -0. Sign is 10 for plus and 11 for minus.
- R9: On every edge, column 10 is loaded with 15 when `overflow_i` is high and with 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_i | input | 4 | Character currently on the serial digit bus |
| data_clk_i | input | 1 | Data scan clock (asynchronous) |
| dp_clk_i | input | 1 | Decimal-point clock, skewed from the data clock (asynchronous) |
| start_i | input | 1 | Start-of-scan strobe, one system clock wide |
| overflow_i | input | 1 | Overflow indicator |
| units_i | input | 3 | Units code for the exponent decode |
| cols_n_o | output | 40 | Ten 4-bit columns in negative logic, column 1 in the low nibble |

## Verification
The assertions assume the following about the inputs:
- `start_i` is synchronous to the system clock.
- `digit_i` is stable across the edge at which a step event lands.
- The two clock inputs may toggle in any pattern, including together.

The bench changes every input only on falling system edges. It holds the digit from the moment it toggles a scan clock until the event has landed, two rising edges later. It deliberately lines up a step event with a start strobe and with an empty selector, so that the cases where writes are dropped are exercised.

// File: rtl/scan_cap_pkg.sv
package scan_cap_pkg;

    localparam int DIGIT_W = 4;

    localparam logic [DIGIT_W-1:0] DP_CODE    = 4'd15;
    localparam logic [DIGIT_W-1:0] SIGN_PLUS  = 4'd10;
    localparam logic [DIGIT_W-1:0] SIGN_MINUS = 4'd11;

    typedef enum logic [2:0] {
        U_HZ   = 3'd0,
        U_KHZ  = 3'd1,
        U_MHZ  = 3'd2,
        U_SEC  = 3'd3,
        U_MSEC = 3'd4,
        U_USEC = 3'd5,
        U_NONE = 3'd6,
        U_RSVD = 3'd7
    } units_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] sign;
        logic [DIGIT_W-1:0] mag;
    } expo_t;

    function automatic expo_t decode_units(input logic [2:0] code);
        expo_t e;
        unique case (units_e'(code))
            U_HZ:    e = '{sign: SIGN_PLUS,  mag: 4'd0};
            U_KHZ:   e = '{sign: SIGN_PLUS,  mag: 4'd3};
            U_MHZ:   e = '{sign: SIGN_PLUS,  mag: 4'd6};
            U_SEC:   e = '{sign: SIGN_MINUS, mag: 4'd0};
            U_MSEC:  e = '{sign: SIGN_MINUS, mag: 4'd3};
            U_USEC:  e = '{sign: SIGN_MINUS, mag: 4'd6};
            U_NONE:  e = '{sign: SIGN_MINUS, mag: 4'd0};
            U_RSVD:  e = '{sign: SIGN_MINUS, mag: 4'd0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/step_detect.sv
module step_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_clk_i,
    input  logic dp_clk_i,
    output logic lead_o,
    output logic trail_o
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_data_q;
    logic [MSB:0] sync_dp_q;
    logic         xor_q;
    logic         xor_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_data_q <= '0;
            sync_dp_q   <= '0;
            xor_q       <= 1'b0;
        end else begin
            sync_data_q <= {sync_data_q[MSB-1:0], data_clk_i};
            sync_dp_q   <= {sync_dp_q[MSB-1:0], dp_clk_i};
            xor_q       <= xor_now;
        end
    end

    assign xor_now = sync_data_q[MSB] ^ sync_dp_q[MSB];
    assign lead_o  = xor_now & ~xor_q;
    assign trail_o = ~xor_now & xor_q;

    AST_NO_DOUBLE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o |=> !lead_o); // R3

    AST_NO_DOUBLE_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        trail_o |=> !trail_o); // R3

endmodule

// File: rtl/token_selector.sv
module token_selector #(
    parameter int NUM_SLOTS = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 step_i,
    output logic [NUM_SLOTS-1:0] tok_n_o,
    output logic                 wr_en_o
);

    localparam logic [NUM_SLOTS-1:0] START_PAT = {{(NUM_SLOTS-1){1'b1}}, 1'b0};
    localparam logic [NUM_SLOTS-1:0] EMPTY_PAT = '1;

    typedef enum logic {
        ST_EMPTY,
        ST_SCAN
    } sel_state_e;

    sel_state_e           state_q;
    sel_state_e           state_d;
    logic [NUM_SLOTS-1:0] tok_n_q;
    logic                 at_last;

    assign at_last = ~tok_n_q[NUM_SLOTS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (start_i) state_d = ST_SCAN;                 // T_START
            end
            ST_SCAN: begin
                if (start_i)              state_d = ST_SCAN;    // T_RESTART
                else if (step_i && at_last) state_d = ST_EMPTY; // T_EXIT
                else                      state_d = ST_SCAN;    // T_STEP / hold
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok_n_q <= EMPTY_PAT;
        end else if (start_i) begin
            tok_n_q <= START_PAT;
        end else if (wr_en_o) begin
            tok_n_q <= {tok_n_q[NUM_SLOTS-2:0], 1'b1};
        end
    end

    assign wr_en_o = (state_q == ST_SCAN) && step_i && !start_i;
    assign tok_n_o = tok_n_q;

    AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~tok_n_q)); // R5

    AST_START_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tok_n_q == START_PAT && state_q == ST_SCAN)); // R7

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !at_last) |=> (tok_n_q == {$past(tok_n_q[NUM_SLOTS-2:0]), 1'b1})); // R4

    AST_EXIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && at_last) |=> (tok_n_q == EMPTY_PAT && state_q == ST_EMPTY)); // R6

    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && !start_i) |=> (tok_n_q == EMPTY_PAT)); // R6

endmodule

// File: rtl/column_bank.sv
module column_bank
    import scan_cap_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    parameter int NUM_COLS  = NUM_SLOTS + 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [NUM_SLOTS-1:0]          tok_n_i,
    input  logic                          lead_i,
    input  logic [DIGIT_W-1:0]            digit_i,
    input  logic                          overflow_i,
    input  logic [2:0]                    units_i,
    output logic [DIGIT_W*NUM_COLS-1:0]   cols_o
);

    localparam int OVF_COL  = NUM_COLS - 1;
    localparam int SIGN_COL = 1;
    localparam int MAG_COL  = 0;

    logic [DIGIT_W-1:0] wr_val;
    logic [DIGIT_W-1:0] ovf_q;
    logic [DIGIT_W-1:0] sign_q;
    logic [DIGIT_W-1:0] mag_q;
    expo_t              expo;

    assign wr_val = lead_i ? DP_CODE : digit_i;
    assign expo   = decode_units(units_i);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam int COL = NUM_SLOTS + 1 - i;
        logic [DIGIT_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en_i && !tok_n_i[i]) begin
                slot_q <= wr_val;
            end
        end

        assign cols_o[COL*DIGIT_W +: DIGIT_W] = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q  <= '0;
            sign_q <= '0;
            mag_q  <= '0;
        end else begin
            ovf_q  <= overflow_i ? DP_CODE : '0;
            sign_q <= expo.sign;
            mag_q  <= expo.mag;
        end
    end

    assign cols_o[OVF_COL*DIGIT_W  +: DIGIT_W] = ovf_q;
    assign cols_o[SIGN_COL*DIGIT_W +: DIGIT_W] = sign_q;
    assign cols_o[MAG_COL*DIGIT_W  +: DIGIT_W] = mag_q;

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_i |=> (ovf_q == DP_CODE)); // R9

    AST_SIGN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sign_q == SIGN_PLUS || sign_q == SIGN_MINUS)); // R8

    AST_MAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (mag_q == 4'd0 || mag_q == 4'd3 || mag_q == 4'd6)); // R8

endmodule

// File: rtl/scan_capture_top.sv
module scan_capture_top
    import scan_cap_pkg::*;
#(
    parameter int NUM_SLOTS   = 7,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_COLS   = NUM_SLOTS + 3,
    localparam int OUT_W      = DIGIT_W * NUM_COLS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               data_clk_i,
    input  logic               dp_clk_i,
    input  logic               start_i,
    input  logic               overflow_i,
    input  logic [2:0]         units_i,
    output logic [OUT_W-1:0]   cols_n_o
);

    logic                 lead;
    logic                 trail;
    logic                 wr_en;
    logic [NUM_SLOTS-1:0] tok_n;
    logic [OUT_W-1:0]     cols;

    step_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_clk_i (data_clk_i),
        .dp_clk_i   (dp_clk_i),
        .lead_o     (lead),
        .trail_o    (trail)
    );

    token_selector #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .step_i  (lead | trail),
        .tok_n_o (tok_n),
        .wr_en_o (wr_en)
    );

    column_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_COLS  (NUM_COLS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .tok_n_i    (tok_n),
        .lead_i     (lead),
        .digit_i    (digit_i),
        .overflow_i (overflow_i),
        .units_i    (units_i),
        .cols_o     (cols)
    );

    assign cols_n_o = ~cols;

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (&tok_n && !start_i) |=> $stable(cols_n_o[(NUM_COLS-1)*DIGIT_W-1 : 2*DIGIT_W])); // R6

endmodule

// File: tb/sim_scan_capture_top.sv
`timescale 1ns/1ps
module sim_scan_capture_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  digit;
    logic        data_clk;
    logic        dp_clk;
    logic        start;
    logic        ovf;
    logic [2:0]  units;
    logic [39:0] cols_n;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    scan_capture_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .digit_i    (digit),
        .data_clk_i (data_clk),
        .dp_clk_i   (dp_clk),
        .start_i    (start),
        .overflow_i (ovf),
        .units_i    (units),
        .cols_n_o   (cols_n)
    );

    // Behavioural reference: mcol[k-1] is column k, mtok = -1 means no token.
    int mcol [10];
    int mtok;
    int m1, m2, m3;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 10; k++) mcol[k] = 0;
            mtok = -1;
            m1 = 0; m2 = 0; m3 = 0;
        end else begin
            if (start) begin
                mtok = 0;
            end else if (m2 != m3 && mtok >= 0) begin
                mcol[8 - mtok] = (m2 == 1) ? 15 : int'(digit);
                mtok = (mtok == 6) ? -1 : mtok + 1;
            end
            mcol[9] = ovf ? 15 : 0;
            case (units)
                3'd0: begin mcol[1] = 10; mcol[0] = 0; end
                3'd1: begin mcol[1] = 10; mcol[0] = 3; end
                3'd2: begin mcol[1] = 10; mcol[0] = 6; end
                3'd4: begin mcol[1] = 11; mcol[0] = 3; end
                3'd5: begin mcol[1] = 11; mcol[0] = 6; end
                default: begin mcol[1] = 11; mcol[0] = 0; end
            endcase
            m3 = m2;
            m2 = m1;
            m1 = int'(data_clk ^ dp_clk);
        end
    end

    function automatic int colv(input int k);
        logic [3:0] v;
        v = ~cols_n[4*k-1 -: 4];
        return int'(v);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("[TB] FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            for (int k = 1; k <= 10; k++) begin
                string tag;
                if (k == 10)      tag = "R9 column 10";
                else if (k <= 2)  tag = "R8 exponent column";
                else              tag = "R4 scanned column";
                chk(tag, colv(k), mcol[k-1]);
            end
        end
    end

    bit xstate = 1'b0;

    // Toggle one scan clock, then wait until the event has landed (R3).
    task automatic step_evt(input bit use_dp, input logic [3:0] d);
        @(negedge clk);
        digit = d;
        if (use_dp) dp_clk = ~dp_clk; else data_clk = ~data_clk;
        xstate = ~xstate;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; digit = 4'd0; data_clk = 1'b0; dp_clk = 1'b0;
        start = 1'b0; ovf = 1'b0; units = 3'd0;
        repeat (4) @(negedge clk);
        chk("R1 reset output all ones", longint'(cols_n), 40'hFF_FFFF_FFFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 Hz sign", colv(2), 10);
        chk("R9 no overflow", colv(10), 0);
        chk("R2 negative logic column 2", longint'(cols_n[7:4]), 4'h5);

        // No token after reset: events write nothing (R1, R6).
        step_evt(1'b0, 4'd4);
        step_evt(1'b1, 4'd4);
        for (int k = 3; k <= 9; k++) chk("R6 empty selector write", colv(k), 0);

        // Full scan, alternating leading and trailing events (R3 R4 R5).
        pulse_start();
        step_evt(1'b0, 4'd9);
        chk("R4 leading writes 15 into column 9", colv(9), 15);
        step_evt(1'b1, 4'd1);
        chk("R4 trailing writes digit into column 8", colv(8), 1);
        step_evt(1'b0, 4'd2);
        step_evt(1'b0, 4'd2);
        step_evt(1'b1, 4'd0);
        step_evt(1'b1, 4'd3);
        step_evt(1'b0, 4'd4);
        chk("R5 column 7", colv(7), 15);
        chk("R5 column 6", colv(6), 2);
        chk("R5 column 5", colv(5), 15);
        chk("R5 column 4", colv(4), 3);
        chk("R5 slot 6 is column 3", colv(3), 15);

        // Token has left after slot 6 (R6).
        step_evt(1'b1, 4'd8);
        chk("R6 after exit column 3", colv(3), 15);
        chk("R6 after exit column 9", colv(9), 15);
        chk("R6 after exit column 8", colv(8), 1);

        // Both clocks toggled together: no event (R3).
        pulse_start();
        @(negedge clk); data_clk = ~data_clk; dp_clk = ~dp_clk;
        repeat (3) @(negedge clk);
        chk("R3 simultaneous toggle no write", colv(9), 15);

        // Restart mid-scan returns to slot 0 (R7).
        step_evt(1'b0, 4'd0);
        step_evt(1'b1, 4'd6);
        chk("R7 first scan column 8", colv(8), 6);
        pulse_start();
        step_evt(1'b0, 4'd0);
        step_evt(1'b1, 4'd8);
        chk("R7 restart rewrites column 8", colv(8), 8);
        chk("R7 restart leaves column 7", colv(7), 15);

        // Start at the same edge as a trailing event: event dropped (R7).
        step_evt(1'b0, 4'd0);
        @(negedge clk);
        digit = 4'd7;
        data_clk = ~data_clk;
        xstate = ~xstate;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R7 coincident event dropped", colv(9), 15);
        step_evt(1'b1, 4'd0);
        step_evt(1'b1, 4'd3);
        chk("R7 token at slot 0 after strobe", colv(8), 3);

        // Units decode over every code (R8).
        for (int u = 0; u < 8; u++) begin
            int es, em;
            @(negedge clk);
            units = 3'(u);
            @(negedge clk);
            es = (u <= 2) ? 10 : 11;
            em = (u == 1 || u == 4) ? 3 : ((u == 2 || u == 5) ? 6 : 0);
            chk("R8 sign", colv(2), es);
            chk("R8 magnitude", colv(1), em);
        end

        // Overflow column (R9).
        @(negedge clk); ovf = 1'b1;
        @(negedge clk);
        chk("R9 overflow set", colv(10), 15);
        chk("R2 overflow negative logic", longint'(cols_n[39:36]), 4'h0);
        @(negedge clk); ovf = 1'b0;
        @(negedge clk);
        chk("R9 overflow clear", colv(10), 0);

        // Random phase, compared against the reference every cycle.
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 2) == 0) data_clk = ~data_clk;
            if ($urandom_range(0, 2) == 0) dp_clk = ~dp_clk;
            if ($urandom_range(0, 3) == 0) digit = 4'($urandom_range(0, 15));
            start = ($urandom_range(0, 39) == 0);
            if ($urandom_range(0, 49) == 0) units = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 29) == 0) ovf = ~ovf;
        end
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("[TB] FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule